// File: doc/BRIEF.md
# Transport Stream Null-Packet Rate Adapter

This block moves an MPEG transport stream of 188-byte packets from an input byte stream running at any rate onto an output byte stream whose pace is set only by a symbol-rate strobe. Packets arriving on the input side are checked for a correct sync byte and a complete length. Packets carrying the null PID (0x1FFF) are thrown away. Every other packet is stored whole in a small packet FIFO.

On each output strobe the block sends one byte. At each output packet boundary it chooses between the oldest buffered packet and a freshly generated null packet. That choice is held for all 188 bytes of the packet. Any program clock reference carried in a buffered packet is increased by the number of 27 MHz ticks the packet spent inside the block, so that the timing seen by a receiver stays consistent.

Both streams share one clock. Each side has its own clock enable. A 27 MHz tick enable drives the internal time base.

Top module: `ts_rate_adapter`

## Requirements
- R1: While reset is held and after its release, `out_start`, `out_data` and `ovf_err` read 0 until the first output strobe.
- R2: `out_start` and `out_data` change only at a clock edge where `out_en` is high. Each such edge presents exactly one byte, and `out_start` is high on every 188th strobe, starting with the first. This holds whatever the input is doing.
- R3: An input packet whose PID is 0x1FFF (13 bits: low 5 bits of byte 1, then byte 2) never reaches the output.
- R4: When no buffered packet is ready at a packet boundary, a null packet is sent: bytes 0x47, 0x1F, 0xFF, 0x10 (payload only, continuity 0), then 184 bytes of 0xFF.
- R5: Accepted packets leave in arrival order with every byte unchanged, except the PCR bytes when a PCR is present.
- R6: The output moves between stuffing and payload only at packet boundaries, so every generated null packet is complete and intact.
- R7: A packet whose first byte is not 0x47 is dropped whole.
- R8: A packet whose start flag is followed by another start flag before 188 bytes have arrived is dropped whole. Bytes that arrive after the 188th byte and before the next start flag are ignored.
- R9: A PCR is present when byte 3 bit 5 is set, byte 4 is nonzero and byte 5 bit 4 is set. It occupies bytes 6–11: a 33-bit base made of bytes 6–9 and byte 10 bit 7, then 6 reserved bits, then a 9-bit extension made of byte 10 bit 0 and byte 11. On output, the PCR equals base×300+extension plus the number of `tick27` edges between the clock edge that took the input start byte and the clock edge that launched the output start byte. The reserved bits are kept.
- R10: The corrected PCR wraps modulo 2^33×300, and its extension always stays below 300.
- R11: The FIFO holds DEPTH packets. A valid packet that arrives when no slot was free at its start is dropped whole and sets `ovf_err`, which then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both streams |
| rst_n | input | 1 | Synchronous active-low reset |
| tick27 | input | 1 | Enable that advances the 27 MHz time base |
| in_en | input | 1 | Input byte strobe |
| in_start | input | 1 | Marks the first byte of an input packet |
| in_data | input | 8 | Input byte |
| out_en | input | 1 | Output byte strobe derived from the symbol rate |
| out_start | output | 1 | Marks the first byte of an output packet |
| out_data | output | 8 | Output byte |
| ovf_err | output | 1 | Sticky FIFO overflow flag |

## Verification
The assertions assume the following about the inputs:
- Output strobes arrive without any condition on the input side.
- Any incoming PCR extension is below 300.
- Reset is asserted only at the start of a run.

Under these assumptions they expect a packet to open with 0x47, the buffer occupancy never to pass DEPTH, and the overflow flag to stay set once raised.

The stimulus keeps within these limits:
- The output strobe runs on a fixed two-in-three pattern, and is paused only to force an overflow.
- Only legal PCR extensions are sent, and `tick27` is held high.
- Input gaps and malformed packets vary only the input side.

// File: rtl/ts_rate_adapter.sv
module ts_rate_adapter #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick27,
  input  logic       in_en,
  input  logic       in_start,
  input  logic [7:0] in_data,
  input  logic       out_en,
  output logic       out_start,
  output logic [7:0] out_data,
  output logic       ovf_err
);
  localparam int PKT = 188;
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int AW  = $clog2(DEPTH * PKT);
  localparam int CW  = $clog2(DEPTH + 1);

  // time values are {base[32:0], ext[8:0]} with ext < 300
  function automatic logic [41:0] pcr_add(input logic [41:0] a, input logic [41:0] b);
    logic [9:0] e;
    logic       c;
    e = {1'b0, a[8:0]} + {1'b0, b[8:0]};
    c = (e >= 10'd300);
    if (c) e = e - 10'd300;
    return {a[41:9] + b[41:9] + {32'd0, c}, e[8:0]};
  endfunction

  function automatic logic [41:0] pcr_sub(input logic [41:0] a, input logic [41:0] b);
    logic [9:0] e;
    logic       w;
    w = (a[8:0] < b[8:0]);
    e = {1'b0, a[8:0]} - {1'b0, b[8:0]};
    if (w) e = e + 10'd300;
    return {a[41:9] - b[41:9] - {32'd0, w}, e[8:0]};
  endfunction

  logic [7:0]    mem [DEPTH*PKT];
  logic [41:0]   s_delta [DEPTH];
  logic          s_pcr [DEPTH];
  logic [41:0]   now_q;

  logic          in_act, room_q, sync_q, af_q, aflen_nz, pflag;
  logic [7:0]    icnt;
  logic [12:0]   pid_q;
  logic [32:0]   pbase;
  logic [8:0]    pext;
  logic [41:0]   arr_q;
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] pkt_cnt;

  logic [7:0]    ocnt;
  logic          src_pay, opcr_en;
  logic [41:0]   opcr;

  logic          take, last_in, keep, commit, dec, room_now, sel_pay;
  logic [7:0]    ipos, obyte, rbyte;
  logic [AW-1:0] waddr, raddr;

  assign take     = in_en && (in_start || in_act);
  assign ipos     = in_start ? 8'd0 : icnt;
  assign last_in  = in_en && !in_start && in_act && (icnt == 8'(PKT - 1));
  assign keep     = sync_q && (pid_q != 13'h1FFF);
  assign commit   = last_in && keep && room_q;
  assign dec      = out_en && src_pay && (ocnt == 8'(PKT - 1));
  assign room_now = (pkt_cnt < CW'(DEPTH)) || dec;
  assign sel_pay  = (ocnt == 8'd0) ? (pkt_cnt != '0) : src_pay;
  assign waddr    = AW'(wptr) * AW'(PKT) + AW'(ipos);
  assign raddr    = AW'(rptr) * AW'(PKT) + AW'(ocnt);
  assign rbyte    = mem[raddr];

  always_ff @(posedge clk)
    if (take && (in_start ? room_now : room_q)) mem[waddr] <= in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) now_q <= '0;
    else if (tick27) now_q <= pcr_add(now_q, 42'd1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_act   <= 1'b0;
      icnt     <= '0;
      room_q   <= 1'b0;
      sync_q   <= 1'b0;
      af_q     <= 1'b0;
      aflen_nz <= 1'b0;
      pflag    <= 1'b0;
      pid_q    <= '0;
      pbase    <= '0;
      pext     <= '0;
      arr_q    <= '0;
      wptr     <= '0;
      ovf_err  <= 1'b0;
    end else begin
      if (in_en && in_start) begin
        in_act <= 1'b1;
        icnt   <= 8'd1;
        room_q <= room_now;
        sync_q <= (in_data == 8'h47);
        arr_q  <= now_q;
      end else if (in_en && in_act) begin
        icnt <= icnt + 8'd1;
        if (last_in) in_act <= 1'b0;
      end
      if (take) begin
        case (ipos)
          8'd1:  pid_q[12:8]  <= in_data[4:0];
          8'd2:  pid_q[7:0]   <= in_data;
          8'd3:  af_q         <= in_data[5];
          8'd4:  aflen_nz     <= (in_data != 8'd0);
          8'd5:  pflag        <= in_data[4];
          8'd6:  pbase[32:25] <= in_data;
          8'd7:  pbase[24:17] <= in_data;
          8'd8:  pbase[16:9]  <= in_data;
          8'd9:  pbase[8:1]   <= in_data;
          8'd10: begin pbase[0] <= in_data[7]; pext[8] <= in_data[0]; end
          8'd11: pext[7:0]    <= in_data;
          default: ;
        endcase
      end
      if (commit) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (last_in && keep && !room_q) ovf_err <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      s_delta[wptr] <= pcr_sub({pbase, pext}, arr_q);
      s_pcr[wptr]   <= af_q && aflen_nz && pflag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pkt_cnt <= '0;
    else pkt_cnt <= pkt_cnt + CW'(commit) - CW'(dec);
  end

  always_comb begin
    if (!sel_pay) begin
      case (ocnt)
        8'd0: obyte = 8'h47;
        8'd1: obyte = 8'h1F;
        8'd3: obyte = 8'h10;
        default: obyte = 8'hFF;
      endcase
    end else begin
      obyte = rbyte;
      if (opcr_en) begin
        case (ocnt)
          8'd6:  obyte = opcr[41:34];
          8'd7:  obyte = opcr[33:26];
          8'd8:  obyte = opcr[25:18];
          8'd9:  obyte = opcr[17:10];
          8'd10: obyte = {opcr[9], rbyte[6:1], opcr[8]};
          8'd11: obyte = opcr[7:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_start <= 1'b0;
      out_data  <= '0;
      ocnt      <= '0;
      src_pay   <= 1'b0;
      opcr_en   <= 1'b0;
      opcr      <= '0;
      rptr      <= '0;
    end else if (out_en) begin
      out_start <= (ocnt == 8'd0);
      out_data  <= obyte;
      ocnt      <= (ocnt == 8'(PKT - 1)) ? 8'd0 : ocnt + 8'd1;
      if (ocnt == 8'd0) begin
        src_pay <= (pkt_cnt != '0);
        opcr_en <= (pkt_cnt != '0) && s_pcr[rptr];
        opcr    <= pcr_add(s_delta[rptr], now_q);
      end
      if (dec) rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
    end
  end
endmodule

// File: rtl/ts_rate_adapter_chk.sv
module ts_rate_adapter_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_en,
  input logic          out_start,
  input logic [7:0]    out_data,
  input logic          ovf_err,
  input logic [CW-1:0] pkt_cnt
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(out_en) |-> ($stable(out_start) && $stable(out_data)));

  p_sync_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> (out_data == 8'h47));

  p_sticky_ovf_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_cnt <= CW'(DEPTH));
endmodule

bind ts_rate_adapter ts_rate_adapter_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_en(out_en), .out_start(out_start),
  .out_data(out_data), .ovf_err(ovf_err), .pkt_cnt(pkt_cnt)
);

// File: tb/ts_rate_adapter_test.sv
module ts_rate_adapter_test;
  logic clk = 1'b0, rst_n = 1'b0, tick27 = 1'b0;
  logic in_en = 1'b0, in_start = 1'b0, out_en = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic out_start, ovf_err;
  logic [7:0] out_data;

  ts_rate_adapter #(.DEPTH(4)) uut (
    .clk(clk), .rst_n(rst_n), .tick27(tick27), .in_en(in_en), .in_start(in_start),
    .in_data(in_data), .out_en(out_en), .out_start(out_start), .out_data(out_data),
    .ovf_err(ovf_err)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  longint cyc = 0;
  bit hold = 1'b1, done = 1'b0;
  int oph = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [1503:0] q_pkt[$];
  longint        q_cyc[$];
  bit            q_pcr[$];
  bit            q_wrap[$];
  string         q_tag[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1503:0] mk(input logic [12:0] pid, input logic [7:0] seed,
                                       input bit pcr, input logic [32:0] b, input logic [8:0] e);
    logic [1503:0] p;
    for (int i = 0; i < 188; i++) p[i*8 +: 8] = seed + 8'(i);
    p[7:0] = 8'h47; p[15:8] = {3'b000, pid[12:8]}; p[23:16] = pid[7:0];
    p[31:24] = pcr ? 8'h30 : 8'h10;
    if (pcr) begin
      p[39:32] = 8'h07; p[47:40] = 8'h10;
      p[55:48] = b[32:25]; p[63:56] = b[24:17]; p[71:64] = b[16:9]; p[79:72] = b[8:1];
      p[87:80] = {b[0], 6'b111111, e[8]}; p[95:88] = e[7:0];
    end
    return p;
  endfunction

  task automatic send(input logic [1503:0] p, input int len, input int extra, input int gap,
                      input bit keep, input bit pcr, input bit wrap, input string tag);
    longint t0 = 0;
    for (int i = 0; i < len + extra; i++) begin
      @(negedge clk);
      in_en = 1'b1; in_start = (i == 0);
      in_data = (i < len) ? p[i*8 +: 8] : 8'h5A;
      if (i == 0) t0 = cyc + 1;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); in_en = 1'b0; in_start = 1'b0;
      end
    end
    @(negedge clk); in_en = 1'b0; in_start = 1'b0;
    if (keep) begin
      q_pkt.push_back(p); q_cyc.push_back(t0); q_pcr.push_back(pcr);
      q_wrap.push_back(wrap); q_tag.push_back(tag);
    end
  endtask

  // scoreboard monitor, also drives the output strobe pattern
  logic [1503:0] cur;
  int obc = 0, nstuff = 0;
  bit started = 1'b0;
  longint st_cyc = 0;

  task automatic judge();
    logic [12:0] pid;
    logic [1503:0] e, ep;
    longint ic, t, m, res;
    logic [32:0] b0, eb;
    logic [8:0] x0, ee;
    bit pc, wr, ok;
    string tg;
    int bad;
    pid = {cur[12:8], cur[23:16]};
    if (pid == 13'h1FFF) begin
      nstuff++;
      bad = -1;
      for (int i = 0; i < 188; i++) begin
        logic [7:0] x;
        x = (i == 0) ? 8'h47 : (i == 1) ? 8'h1F : (i == 3) ? 8'h10 : 8'hFF;
        if (bad < 0 && cur[i*8 +: 8] != x) bad = i;
      end
      chk(bad < 0, "R4 R3 R6", "stuffing packet byte",
          bad < 0 ? 0 : longint'(cur[bad*8 +: 8]), bad);
      return;
    end
    if (q_pkt.size() == 0) begin
      chk(1'b0, "R5", "unexpected payload pid", pid, 0);
      return;
    end
    e = q_pkt.pop_front(); ic = q_cyc.pop_front(); pc = q_pcr.pop_front();
    wr = q_wrap.pop_front(); tg = q_tag.pop_front();
    ok = 1'b1; bad = 0;
    for (int i = 0; i < 188; i++)
      if (!(pc && i >= 6 && i <= 11) && cur[i*8 +: 8] != e[i*8 +: 8]) begin
        if (ok) bad = i;
        ok = 1'b0;
      end
    chk(ok, tg, "payload byte", cur[bad*8 +: 8], e[bad*8 +: 8]);
    if (pc) begin
      b0 = {e[55:48], e[63:56], e[71:64], e[79:72], e[87]};
      x0 = {e[80], e[95:88]};
      m = (longint'(1) << 33) * 300;
      res = st_cyc - ic;
      t = (longint'(b0) * 300 + longint'(x0) + res) % m;
      eb = 33'(t / 300); ee = 9'(t % 300);
      ep = e;
      ep[55:48] = eb[32:25]; ep[63:56] = eb[24:17]; ep[71:64] = eb[16:9]; ep[79:72] = eb[8:1];
      ep[87:80] = {eb[0], e[86:81], ee[8]}; ep[95:88] = ee[7:0];
      chk(cur[95:48] == ep[95:48], wr ? "R10" : "R9", "PCR bytes 6..11",
          longint'(cur[95:48]), longint'(ep[95:48]));
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_en) begin
      if (out_start) begin
        if (started) chk(obc == 188, "R2", "bytes between packet starts", obc, 188);
        obc = 0; started = 1'b1; st_cyc = cyc;
      end
      if (started) begin
        if (obc < 188) cur[obc*8 +: 8] = out_data;
        obc++;
        if (obc == 188) judge();
      end
    end
    if (hold || !rst_n) out_en = 1'b0;
    else begin
      out_en = (oph != 2);
      oph = (oph == 2) ? 0 : oph + 1;
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic drain();
    while (q_pkt.size() != 0) @(negedge clk);
    repeat (400) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "R2", "watchdog expired", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [1503:0] p;
    repeat (4) @(negedge clk);
    chk(out_start == 1'b0 && out_data == 8'h00 && ovf_err == 1'b0, "R1", "outputs in reset",
        {out_start, out_data, ovf_err}, 0);
    rst_n = 1'b1; tick27 = 1'b1;
    @(negedge clk);
    chk(out_start == 1'b0 && out_data == 8'h00 && ovf_err == 1'b0, "R1", "outputs after reset",
        {out_start, out_data, ovf_err}, 0);
    hold = 1'b0;
    repeat (500) @(negedge clk);

    send(mk(13'h0100, 8'h11, 1'b0, 0, 0), 188, 0, 0, 1'b1, 1'b0, 1'b0, "R5");
    p = mk(13'h1FFF, 8'h00, 1'b0, 0, 0);
    for (int i = 4; i < 188; i++) p[i*8 +: 8] = 8'hAA;
    send(p, 188, 0, 1, 1'b0, 1'b0, 1'b0, "R3");
    send(mk(13'h0101, 8'h22, 1'b1, 33'd12345678, 9'd150), 188, 0, 3, 1'b1, 1'b1, 1'b0, "R9");
    p = mk(13'h0200, 8'h33, 1'b0, 0, 0); p[7:0] = 8'h46;
    send(p, 188, 0, 0, 1'b0, 1'b0, 1'b0, "R7");
    send(mk(13'h0102, 8'h44, 1'b0, 0, 0), 188, 0, 1, 1'b1, 1'b0, 1'b0, "R7");
    send(mk(13'h0300, 8'h55, 1'b0, 0, 0), 100, 0, 0, 1'b0, 1'b0, 1'b0, "R8");
    send(mk(13'h0103, 8'h66, 1'b0, 0, 0), 188, 6, 0, 1'b1, 1'b0, 1'b0, "R8");
    send(mk(13'h0104, 8'h77, 1'b0, 0, 0), 188, 0, 2, 1'b1, 1'b0, 1'b0, "R8");
    send(mk(13'h0105, 8'h88, 1'b1, 33'h1FFFFFFFF, 9'd299), 188, 0, 0, 1'b1, 1'b1, 1'b1, "R10");
    drain();

    hold = 1'b1;
    repeat (3) @(negedge clk);
    send(mk(13'h0110, 8'h01, 1'b0, 0, 0), 188, 0, 0, 1'b1, 1'b0, 1'b0, "R11");
    send(mk(13'h0111, 8'h02, 1'b1, 33'd999, 9'd10), 188, 0, 0, 1'b1, 1'b1, 1'b0, "R9");
    send(mk(13'h0112, 8'h03, 1'b0, 0, 0), 188, 0, 0, 1'b1, 1'b0, 1'b0, "R11");
    send(mk(13'h0113, 8'h04, 1'b0, 0, 0), 188, 0, 0, 1'b1, 1'b0, 1'b0, "R11");
    chk(ovf_err == 1'b0, "R11", "flag with FIFO just full", ovf_err, 0);
    send(mk(13'h0114, 8'h05, 1'b0, 0, 0), 188, 0, 0, 1'b0, 1'b0, 1'b0, "R11");
    @(negedge clk);
    chk(ovf_err == 1'b1, "R11", "flag after drop", ovf_err, 1);
    hold = 1'b0;
    drain();
    chk(ovf_err == 1'b1, "R11", "flag is sticky", ovf_err, 1);
    chk(q_pkt.size() == 0, "R5", "undelivered packets", q_pkt.size(), 0);
    chk(nstuff > 0, "R4", "stuffing packets seen", nstuff, 1);
    if (!done) begin
      done = 1'b1;
      finish_run();
    end
  end
endmodule